// File: doc/BRIEF.md
# Cache Maintenance Range Chunking Sequencer

This block takes a byte range, given as a start address and an exclusive end address, together with a maintenance mode. It turns that range into a stream of commands that a downstream cache range engine can legally execute. Each command carries an opcode, an inclusive first-line address and an inclusive last-line address. A valid/ready handshake hands each command over. When the last command has been accepted, a one-cycle done pulse closes the sequence. The block only aligns and splits the range. It never runs the commands itself.

There are three modes. Invalidate mode must not destroy dirty data that shares a line with bytes outside the range. So a partial line at either edge receives a single-line clean-and-invalidate, and only the whole lines in between are range-invalidated. Clean and flush modes widen the range outward to whole lines. Flush issues a range clean and then a range invalidate for every chunk. Every chunk stops at the earliest of three points: the (aligned) end, 1024 bytes past its own start, or the next 4 KiB page boundary. When write-through is forced, the cache never holds dirty data, so a clean request finishes with no commands.

The controller has six states:
- S_IDLE waits for go.
- S_HEAD issues the partial first line.
- S_TAIL issues the partial last line.
- S_RANGE_A issues the first range command of a chunk.
- S_RANGE_B issues the second, invalidate, command of a flush chunk.
- S_DONE raises done for one cycle.

The transitions are:
- S_IDLE→S_DONE on an empty range or a write-through clean.
- S_IDLE→S_HEAD, S_IDLE→S_TAIL or S_IDLE→S_RANGE_A on go, whichever work comes first.
- S_HEAD→S_TAIL, S_HEAD→S_RANGE_A or S_HEAD→S_DONE on acceptance.
- S_TAIL→S_RANGE_A or S_TAIL→S_DONE on acceptance.
- S_RANGE_A→S_RANGE_B on acceptance in flush mode.
- S_RANGE_A→S_RANGE_A or S_RANGE_B→S_RANGE_A while chunks remain.
- S_RANGE_A→S_DONE or S_RANGE_B→S_DONE after the last chunk.
- S_DONE→S_IDLE always.

Top module: `maint_range_seq`

## Requirements
- R1: While reset is active and right after it, cmd_valid and done are 0.
- R2: A presented command (cmd_op, cmd_start, cmd_end) stays valid and unchanged until a cycle in which cmd_ready is 1. Each accepted command then moves on to the next one.
- R3: A range command covers the lines from chunk start to chunk end minus 32 inclusive, with both addresses 32-byte aligned. The chunk end is the smallest of three values: the aligned end, chunk start plus 1024, and the next 4 KiB boundary above chunk start. Chunks tile the aligned range in ascending order. Range invalidate uses opcode 1.
- R4: No command spans more than 1024 bytes, so cmd_end - cmd_start < 1024.
- R5: No command crosses a 4 KiB page, so cmd_start and cmd_end agree in address bits 31:12.
- R6: In invalidate mode (mode 0), a start address that is not a multiple of 32 causes a first command with opcode 0 (single-line clean-and-invalidate), whose start and end are both the line containing the start. The start is then rounded up to the next line.
- R7: In invalidate mode, once the start has been adjusted, a command with opcode 0 for the line containing the end follows if two conditions hold: the adjusted start is below the end, and the end is not a multiple of 32. The end is then rounded down before the range commands.
- R8: In clean mode (mode 1), the start rounds down and the end rounds up to 32-byte boundaries. Each chunk produces one command with opcode 2 (range clean), and opcode 0 never appears.
- R9: In flush mode (mode 2 or 3), the range is aligned as in clean mode. Each chunk produces opcode 2 and then opcode 1, both with the same addresses.
- R10: With wt_override at 1 when go is taken, clean mode emits nothing and raises done in the cycle after go. In the other modes wt_override has no effect.
- R11: If the aligned range is empty, done rises in the cycle after go and no command is emitted.
- R12: done is a single-cycle pulse that never coincides with cmd_valid. go and all request inputs are ignored from the cycle after go until done has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Starts a sequence when the block is idle |
| mode | input | 2 | 0 invalidate, 1 clean, 2 or 3 flush |
| wt_override | input | 1 | Write-through forced; clean becomes a no-op |
| start_addr | input | 32 | First byte of the range |
| end_addr | input | 32 | Byte after the last byte of the range |
| cmd_valid | output | 1 | A command is presented |
| cmd_ready | input | 1 | Downstream takes the command this cycle |
| cmd_op | output | 2 | 0 line clean-and-invalidate, 1 range invalidate, 2 range clean |
| cmd_start | output | 32 | Inclusive first-line address |
| cmd_end | output | 32 | Inclusive last-line address |
| done | output | 1 | One-cycle pulse ending the sequence |

## Verification
Two functions can collide in one cycle. One is the acceptance of a command that may be the last of a chunk or of the sequence. The other is a new go request carrying a different mode and range. A stalling cmd_ready in the same cycle adds the hold-stable rule to the mix. The bench provokes this by holding go high, with altered mode and addresses, through whole sequences while cmd_ready follows a pseudo-random pattern. It judges the result by comparing every accepted command, and the cycle of done, with an arithmetic model of the original request.

// File: rtl/maint_range_pkg.sv
package maint_range_pkg;
    typedef enum logic [1:0] {
        OP_LINE_CI     = 2'd0,
        OP_RANGE_INV   = 2'd1,
        OP_RANGE_CLEAN = 2'd2
    } maint_op_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_HEAD    = 3'd1,
        S_TAIL    = 3'd2,
        S_RANGE_A = 3'd3,
        S_RANGE_B = 3'd4,
        S_DONE    = 3'd5
    } seq_state_e;
endpackage

// File: rtl/maint_edge_align.sv
module maint_edge_align #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              inv_mode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              head_need,
    output logic              tail_need,
    output logic [ADDR_W-1:0] head_line,
    output logic [ADDR_W-1:0] tail_line,
    output logic [ADDR_W-1:0] cur_init,
    output logic [ADDR_W-1:0] lim_init
);
    localparam int LINE_SH = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    logic start_part, end_part;

    always_comb begin
        start_part = |start_addr[LINE_SH-1:0];
        end_part   = |end_addr[LINE_SH-1:0];
        head_line  = start_addr & ~LINE_MASK;
        tail_line  = end_addr & ~LINE_MASK;
        head_need  = inv_mode && start_part;
        if (inv_mode) begin
            cur_init  = start_part ? head_line + ADDR_W'(LINE_BYTES) : start_addr;
            lim_init  = tail_line;
            tail_need = end_part && (cur_init < end_addr);
        end else begin
            cur_init  = head_line;
            lim_init  = end_part ? tail_line + ADDR_W'(LINE_BYTES) : end_addr;
            tail_need = 1'b0;
        end
    end
endmodule

// File: rtl/maint_chunk_limit.sv
module maint_chunk_limit #(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] lim,
    output logic [ADDR_W-1:0] chunk_end
);
    localparam int PAGE_SH = $clog2(PAGE_BYTES);
    localparam int EXT_W   = ADDR_W + 1;

    logic [EXT_W-1:0] by_size, by_page, ext_lim, pick;

    always_comb begin
        by_size = {1'b0, cur} + EXT_W'(CHUNK_BYTES);
        by_page = ({1'b0, cur} >> PAGE_SH) + EXT_W'(1);
        by_page = by_page << PAGE_SH;
        ext_lim = {1'b0, lim};
        pick    = (by_size < by_page) ? by_size : by_page;
        if (ext_lim < pick) pick = ext_lim;
        chunk_end = pick[ADDR_W-1:0];
    end
endmodule

// File: rtl/maint_range_seq.sv
module maint_range_seq
    import maint_range_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [1:0]        mode,
    input  logic              wt_override,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_start,
    output logic [ADDR_W-1:0] cmd_end,
    output logic              done
);
    localparam int LINE_SH = $clog2(LINE_BYTES);
    localparam int PAGE_SH = $clog2(PAGE_BYTES);

    seq_state_e        st, st_n;
    logic [ADDR_W-1:0] cur, cur_n, lim, head_q, tail_q, chunk_end;
    logic              inv_q, flush_q, tail_need_q, take;
    logic              req_inv, req_clean;
    logic              a_head, a_tail;
    logic [ADDR_W-1:0] a_head_line, a_tail_line, a_cur, a_lim;

    assign req_inv   = (mode == 2'd0);
    assign req_clean = (mode == 2'd1);
    assign take      = cmd_valid && cmd_ready;

    maint_edge_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
        .inv_mode(req_inv), .start_addr(start_addr), .end_addr(end_addr),
        .head_need(a_head), .tail_need(a_tail),
        .head_line(a_head_line), .tail_line(a_tail_line),
        .cur_init(a_cur), .lim_init(a_lim)
    );

    maint_chunk_limit #(.ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES),
                        .PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .cur(cur), .lim(lim), .chunk_end(chunk_end)
    );

    // next state
    always_comb begin
        st_n  = st;
        cur_n = cur;
        unique case (st)
            S_IDLE: if (go) begin
                cur_n = a_cur;
                if (req_clean && wt_override) st_n = S_DONE;
                else if (a_head)              st_n = S_HEAD;
                else if (a_tail)              st_n = S_TAIL;
                else if (a_cur < a_lim)       st_n = S_RANGE_A;
                else                          st_n = S_DONE;
            end
            S_HEAD: if (take) begin
                if (tail_need_q)    st_n = S_TAIL;
                else if (cur < lim) st_n = S_RANGE_A;
                else                st_n = S_DONE;
            end
            S_TAIL: if (take) st_n = (cur < lim) ? S_RANGE_A : S_DONE;
            S_RANGE_A: if (take) begin
                if (flush_q) st_n = S_RANGE_B;
                else begin
                    cur_n = chunk_end;
                    st_n  = (chunk_end < lim) ? S_RANGE_A : S_DONE;
                end
            end
            S_RANGE_B: if (take) begin
                cur_n = chunk_end;
                st_n  = (chunk_end < lim) ? S_RANGE_A : S_DONE;
            end
            S_DONE:  st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            cur         <= '0;
            lim         <= '0;
            head_q      <= '0;
            tail_q      <= '0;
            inv_q       <= 1'b0;
            flush_q     <= 1'b0;
            tail_need_q <= 1'b0;
        end else begin
            st  <= st_n;
            cur <= cur_n;
            if (st == S_IDLE && go) begin
                lim         <= a_lim;
                head_q      <= a_head_line;
                tail_q      <= a_tail_line;
                inv_q       <= req_inv;
                flush_q     <= mode[1];
                tail_need_q <= a_tail;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_LINE_CI;
        cmd_start = cur;
        cmd_end   = chunk_end - ADDR_W'(LINE_BYTES);
        done      = (st == S_DONE);
        unique case (st)
            S_HEAD: begin
                cmd_valid = 1'b1;
                cmd_start = head_q;
                cmd_end   = head_q;
            end
            S_TAIL: begin
                cmd_valid = 1'b1;
                cmd_start = tail_q;
                cmd_end   = tail_q;
            end
            S_RANGE_A: begin
                cmd_valid = 1'b1;
                cmd_op    = inv_q ? OP_RANGE_INV : OP_RANGE_CLEAN;
            end
            S_RANGE_B: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_RANGE_INV;
            end
            default: cmd_valid = 1'b0;
        endcase
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op)
            && $stable(cmd_start) && $stable(cmd_end));
    // R3
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_start[LINE_SH-1:0] == '0) && (cmd_end[LINE_SH-1:0] == '0));
    // R4
    chunk_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_end - cmd_start) < ADDR_W'(CHUNK_BYTES));
    // R5
    page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_start[ADDR_W-1:PAGE_SH] == cmd_end[ADDR_W-1:PAGE_SH]);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);
endmodule

// File: tb/maint_range_seq_bench.sv
module maint_range_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        wt_override = 1'b0;
    logic [31:0] start_addr = '0, end_addr = '0;
    logic        cmd_valid, cmd_ready = 1'b0, done;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_start, cmd_end;

    always #4 clk = ~clk;

    maint_range_seq u_maint_range_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .wt_override(wt_override),
        .start_addr(start_addr), .end_addr(end_addr), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_start(cmd_start),
        .cmd_end(cmd_end), .done(done)
    );

    int checks = 0, fails = 0, total_cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [1:0]  exp_op[64];
    longint      exp_s[64], exp_e[64];
    string       exp_tag[64];
    int          exp_n;

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic add_exp(logic [1:0] op, longint s, longint e, string tag);
        if (exp_n < 64) begin
            exp_op[exp_n] = op; exp_s[exp_n] = s; exp_e[exp_n] = e; exp_tag[exp_n] = tag;
        end
        exp_n++;
    endtask

    task automatic build_model(logic [1:0] md, logic wt, longint sa, longint ea);
        longint s = sa, e = ea, ce, pg;
        exp_n = 0;
        if (md == 2'd1 && wt) return;                  // R10
        if (md == 2'd0) begin
            if (s % 32 != 0) begin                     // R6
                add_exp(2'd0, s - s % 32, s - s % 32, "R6");
                s = s - s % 32 + 32;
            end
            if (s < e && e % 32 != 0) add_exp(2'd0, e - e % 32, e - e % 32, "R7");
            e = e - e % 32;
        end else begin
            s = s - s % 32;
            if (e % 32 != 0) e = e - e % 32 + 32;
        end
        while (s < e) begin
            ce = s + 1024;
            pg = (s / 4096 + 1) * 4096;
            if (pg < ce) ce = pg;
            if (e < ce) ce = e;
            if (md == 2'd0) add_exp(2'd1, s, ce - 32, "R3");
            else if (md == 2'd1) add_exp(2'd2, s, ce - 32, "R8");
            else begin
                add_exp(2'd2, s, ce - 32, "R9");
                add_exp(2'd1, s, ce - 32, "R9");
            end
            s = ce;
        end
    endtask

    task automatic run_seq(logic [1:0] md, logic wt, logic [31:0] sa, logic [31:0] ea, bit jam_go);
        int got = 0, cyc = 0;
        bit fin = 0, stall_prev = 0;
        logic [1:0] p_op = '0;
        logic [31:0] p_s = '0, p_e = '0;
        build_model(md, wt, sa, ea);
        @(negedge clk);
        mode = md; wt_override = wt; start_addr = sa; end_addr = ea; go = 1'b1;
        while (!fin && cyc < 3000) begin
            @(negedge clk);
            cyc++; total_cyc++;
            if (done) begin
                fin = 1; go = 1'b0;
                mode = md; start_addr = sa; end_addr = ea;
                check(got == exp_n, (exp_n == 0) ? "R11" : "R3", "command count", got, exp_n);
                if (exp_n == 0) check(cyc == 1, (md == 2'd1 && wt) ? "R10" : "R11", "done cycle", cyc, 1);
            end else begin
                if (jam_go) begin   // R12: ignored while busy
                    go = 1'b1; mode = ~md; start_addr = sa + 32'd100; end_addr = ea + 32'd700;
                end else go = 1'b0;
                if (stall_prev)
                    check(cmd_valid && cmd_op == p_op && cmd_start == p_s && cmd_end == p_e,
                          "R2", "held command", cmd_start, p_s);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cmd_ready = lfsr[0] | lfsr[3];
                if (cmd_valid) begin
                    if (cmd_ready) begin
                        if (got < exp_n && got < 64) begin
                            check(cmd_op == exp_op[got], exp_tag[got], "opcode", cmd_op, exp_op[got]);
                            check(cmd_start == exp_s[got], exp_tag[got], "start", cmd_start, exp_s[got]);
                            check(cmd_end == exp_e[got], exp_tag[got], "end", cmd_end, exp_e[got]);
                        end
                        check(cmd_end - cmd_start < 1024, "R4", "span", cmd_end - cmd_start, 1024);
                        check(cmd_end[31:12] == cmd_start[31:12], "R5", "page", cmd_end, cmd_start);
                        got++;
                    end
                    stall_prev = !cmd_ready;
                    p_op = cmd_op; p_s = cmd_start; p_e = cmd_end;
                end else stall_prev = 0;
            end
        end
        if (!fin) check(0, "R12", "sequence watchdog", cyc, 3000);
        @(negedge clk);
        total_cyc++;
        check(!done && !cmd_valid, "R12", "done single pulse", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!cmd_valid && !done, "R1", "reset outputs", {cmd_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid && !done, "R1", "after reset", {cmd_valid, done}, 0);
        for (int md = 0; md < 4; md++)
            for (int wt = 0; wt < 2; wt++)
                for (int i = 0; i < 12; i++)
                    for (int j = 0; j < 12; j++)
                        run_seq(2'(md), 1'(wt), 32'(4096 - 160 + i * 29),
                                32'(4096 - 160 + i * 29 + j * 53), 1'b0);
        run_seq(2'd0, 1'b0, 32'd100, 32'd6000, 1'b0);
        run_seq(2'd2, 1'b0, 32'd4000, 32'd9000, 1'b1);
        run_seq(2'd1, 1'b0, 32'd0, 32'd8192, 1'b1);
        run_seq(2'd0, 1'b1, 32'd33, 32'd3000, 1'b1);
        run_seq(2'd1, 1'b1, 32'd33, 32'd3000, 1'b0);
        run_seq(2'd3, 1'b1, 32'd2047, 32'd2049, 1'b0);
        run_seq(2'd0, 1'b0, 32'd65, 32'd70, 1'b0);
        run_seq(2'd0, 1'b0, 32'd64, 32'd64, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 190000);
        checks++; fails++;
        $display("FAIL R12 global watchdog actual=%0d expected=%0d", total_cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule